// File: doc/BRIEF.md
# Short-Burst Register-Driven SPI Master

This block is an SPI master for brief command-and-reply exchanges, controlled through a small word-wide register bus. Software places up to eight outgoing bytes in two 32-bit data words, called the command word and the payload word. It then writes the transmit and receive byte counts to the transfer register, and writes the same value again with the go bit set. The engine then clocks out the transmit bytes and follows them at once with the requested number of receive bytes. The received bytes overwrite the same two data words, and the busy flag falls.

Chip select is not tied to a transfer. Software drives it through a select register, so the line can stay asserted across several transfers that make up one message. A divider field in the configuration register sets the serial clock rate. The bus is SPI mode 0: the clock idles low, data is launched on the falling edge and sampled on the rising edge, and each byte goes out MSB first.

Top module: `sbspi_master`

## Requirements
- R1: After reset, every register reads zero except the configuration word, which reads 0x0003_0000 (divider 3). `spi_cs_n` is 1, and `spi_sck` and `spi_mosi` are 0. Unmapped offsets always read zero.
- R2: The command word (0x04) and the payload word (0x08) read back as written. The configuration word (0x28) keeps only the divider at bits [27:16] and three control bits at [31:29]. The select register (0x38) keeps only bit 0, and `spi_cs_n` is its inverse.
- R3: Transfer register (0x00) layout: transmit count at [3:0], receive count at [7:4], go at bit 8, busy at bit 16. A write with go set is accepted when the block is idle and either count is nonzero. Go always reads 0. Busy reads 1 from the accepting edge for exactly 2·(div+2)·8·(tx+rx) clocks.
- R4: `spi_sck` stays low while idle. During a transfer it is low for div+2 clocks and then high for div+2 clocks for each bit, starting with a low half right after the accepting edge.
- R5: Outgoing byte i is taken from command[7:0], command[31:24], command[23:16], command[15:8], payload[7:0], payload[15:8], payload[23:16] and payload[31:24] for i = 0..7. Bytes go out in index order, MSB first. `spi_mosi` changes only as `spi_sck` falls, and it is 0 during the receive phase and while idle.
- R6: `spi_miso` is sampled on each rising `spi_sck` of the receive phase, MSB first. Received byte j lands in payload[8j+7:8j] for j = 0..3 and in command[8(j-4)+7:8(j-4)] for j = 4..7. Bytes at or beyond the receive count keep their old value.
- R7: A transmit count of zero with a nonzero receive count performs a receive-only transfer.
- R8: A count field above 8 behaves as 8, and it reads back as written.
- R9: While busy, every register write is ignored, including another go.
- R10: A go with both counts zero starts nothing. The counts are still stored.
- R11: Writing the counts with go clear stores them and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
Read data appears in the same cycle as the address, so the bench compares each read half a clock after driving the address. `spi_sck` and `spi_mosi` follow the accepting edge with no latency: in clock k after acceptance, bit k/(2·(div+2)) is on `spi_mosi`, and the clock is high in the second half of that window. The bench model counts those clocks and compares both pins on every falling system clock. Busy falls, and the received bytes appear in the data words, on edge 2·(div+2)·8·(tx+rx). The bench reads the transfer register every clock while the transfer runs, so a drop one clock early or late shows as a mismatch.

// File: rtl/sbspi_pkg.sv
// Shared constants and helpers for the short-burst SPI master.
// Assumes a 32-bit register bus and an eight-byte burst limit.
package sbspi_pkg;

    localparam int WORD_W   = 32;
    localparam int NBYTES   = 8;
    localparam int FRAME_W  = NBYTES * 8;
    localparam int CNT_W    = 4;

    localparam int OFS_XFER = 'h00;
    localparam int OFS_CMD  = 'h04;
    localparam int OFS_PAY  = 'h08;
    localparam int OFS_CFG  = 'h28;
    localparam int OFS_SEL  = 'h38;

    localparam int BIT_GO   = 8;
    localparam int BIT_BUSY = 16;
    localparam int CFG_DIV_LSB = 16;

    // Clamp a raw count field to the burst limit.
    function automatic logic [CNT_W-1:0] eff_count(input logic [CNT_W-1:0] raw);
        return (raw > CNT_W'(NBYTES)) ? CNT_W'(NBYTES) : raw;
    endfunction

endpackage

// File: rtl/sbspi_regs.sv
// Register block: decodes bus writes, builds the outgoing frame from the
// command/payload words and folds received bytes back into them.
// Assumes the shifter raises done_i only while busy; writes are dropped while busy.
module sbspi_regs
    import sbspi_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter int          DIV_W   = 12,
    parameter int unsigned DIV_RST = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    input  logic               done_i,
    input  logic [FRAME_W-1:0] rx_frame_i,
    output logic               busy_o,
    output logic               start_o,
    output logic [FRAME_W-1:0] tx_frame_o,
    output logic [CNT_W-1:0]   txe_o,
    output logic [CNT_W-1:0]   rxe_o,
    output logic [DIV_W-1:0]   div_o,
    output logic               cs_n_o
);

    logic [WORD_W-1:0] cmd_q, pay_q, cmd_n, pay_n;
    logic [CNT_W-1:0]  txc_q, rxc_q;
    logic [DIV_W-1:0]  div_q;
    logic [2:0]        ctl_q;
    logic              sel_q, busy_q;
    logic              wr_ok;
    logic              hit_xfer, hit_cmd, hit_pay, hit_cfg, hit_sel;
    logic [7:0]        txb   [NBYTES];
    logic [7:0]        rxb   [NBYTES];
    logic              rxhit [NBYTES];

    assign hit_xfer = (bus_addr == ADDR_W'(OFS_XFER));
    assign hit_cmd  = (bus_addr == ADDR_W'(OFS_CMD));
    assign hit_pay  = (bus_addr == ADDR_W'(OFS_PAY));
    assign hit_cfg  = (bus_addr == ADDR_W'(OFS_CFG));
    assign hit_sel  = (bus_addr == ADDR_W'(OFS_SEL));

    assign wr_ok   = bus_wr && !busy_q;
    assign start_o = wr_ok && hit_xfer && bus_wdata[BIT_GO] && (bus_wdata[7:0] != 8'd0);
    assign txe_o   = eff_count(txc_q);
    assign rxe_o   = eff_count(rxc_q);
    assign div_o   = div_q;
    assign busy_o  = busy_q;
    assign cs_n_o  = !sel_q;

    // Map outgoing byte indices onto the command/payload words.
    always_comb begin
        txb[0] = cmd_q[7:0];
        txb[1] = cmd_q[31:24];
        txb[2] = cmd_q[23:16];
        txb[3] = cmd_q[15:8];
        for (int i = 0; i < 4; i++) txb[4+i] = pay_q[8*i +: 8];
    end

    // Pack enabled outgoing bytes MSB-first into the frame, zeroing the rest.
    always_comb begin
        tx_frame_o = '0;
        for (int i = 0; i < NBYTES; i++)
            if (i < int'(txe_o)) tx_frame_o[FRAME_W-1-8*i -: 8] = txb[i];
    end

    // Pick received bytes out of the tail of the receive window.
    always_comb begin
        for (int j = 0; j < NBYTES; j++) begin
            rxhit[j] = (j < int'(rxe_o));
            rxb[j]   = rxhit[j] ? 8'(rx_frame_i >> (8 * (int'(rxe_o) - 1 - j))) : 8'd0;
        end
    end

    // Merge received bytes into next-state copies of the data words.
    always_comb begin
        cmd_n = cmd_q;
        pay_n = pay_q;
        for (int j = 0; j < 4; j++) begin
            if (rxhit[j])   pay_n[8*j +: 8] = rxb[j];
            if (rxhit[j+4]) cmd_n[8*j +: 8] = rxb[j+4];
        end
    end

    // Register state: bus writes when idle, result capture on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            pay_q  <= '0;
            txc_q  <= '0;
            rxc_q  <= '0;
            div_q  <= DIV_W'(DIV_RST);
            ctl_q  <= '0;
            sel_q  <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            if (start_o)     busy_q <= 1'b1;
            else if (done_i) busy_q <= 1'b0;
            if (done_i) begin
                cmd_q <= cmd_n;
                pay_q <= pay_n;
            end
            if (wr_ok) begin
                if (hit_xfer) begin
                    txc_q <= bus_wdata[3:0];
                    rxc_q <= bus_wdata[7:4];
                end
                if (hit_cmd) cmd_q <= bus_wdata;
                if (hit_pay) pay_q <= bus_wdata;
                if (hit_cfg) begin
                    div_q <= bus_wdata[CFG_DIV_LSB +: DIV_W];
                    ctl_q <= bus_wdata[31:29];
                end
                if (hit_sel) sel_q <= bus_wdata[0];
            end
        end
    end

    // Read multiplexer, no side effects.
    always_comb begin
        bus_rdata = '0;
        if (hit_xfer) begin
            bus_rdata[3:0]      = txc_q;
            bus_rdata[7:4]      = rxc_q;
            bus_rdata[BIT_BUSY] = busy_q;
        end
        if (hit_cmd) bus_rdata = cmd_q;
        if (hit_pay) bus_rdata = pay_q;
        if (hit_cfg) begin
            bus_rdata[CFG_DIV_LSB +: DIV_W] = div_q;
            bus_rdata[31:29]                = ctl_q;
        end
        if (hit_sel) bus_rdata[0] = sel_q;
    end

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && $past(busy_q) |-> $stable(cmd_q) && $stable(pay_q) && $stable(div_q)); // R9
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> busy_q); // R3

endmodule

// File: rtl/sbspi_clkgen.sv
// Half-period timer: pulses half_end_o every (div+2) clocks while run_i is high.
// Assumes div_i is held steady while run_i is high.
module sbspi_clkgen #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             half_end_o
);

    localparam int CT_W = DIV_W + 1;

    logic [CT_W-1:0] cnt_q;
    logic [CT_W-1:0] lim;

    assign lim        = CT_W'(div_i) + CT_W'(1);
    assign half_end_o = run_i && (cnt_q == lim);

    // Count clocks within the current half period; parked at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!run_i)     cnt_q <= '0;
        else if (half_end_o) cnt_q <= '0;
        else                 cnt_q <= cnt_q + CT_W'(1);
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> cnt_q <= lim); // R4

endmodule

// File: rtl/sbspi_shift.sv
// Bit engine: drives SCK and MOSI in mode 0 and collects MISO samples.
// Assumes load_i pulses once per transfer and the counts are stable while run_i is high.
module sbspi_shift
    import sbspi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] tx_frame_i,
    input  logic [CNT_W-1:0]   txe_i,
    input  logic [CNT_W-1:0]   rxe_i,
    input  logic               half_end_i,
    input  logic               miso_i,
    output logic               sck_o,
    output logic               mosi_o,
    output logic [FRAME_W-1:0] rx_frame_o,
    output logic               done_o
);

    localparam int IX_W = $clog2(2 * FRAME_W) + 1;

    logic               sck_q;
    logic [FRAME_W-1:0] tx_sr, rx_sr;
    logic [IX_W-1:0]    idx_q, nbits, last_idx;
    logic               last_bit;

    assign nbits      = (IX_W'(txe_i) + IX_W'(rxe_i)) << 3;
    assign last_idx   = nbits - IX_W'(1);
    assign last_bit   = (idx_q == last_idx);
    assign done_o     = run_i && half_end_i && sck_q && last_bit;
    assign sck_o      = sck_q;
    assign mosi_o     = tx_sr[FRAME_W-1];
    assign rx_frame_o = rx_sr;

    // Toggle SCK each half period; sample on rise, advance on fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            tx_sr <= '0;
            rx_sr <= '0;
            idx_q <= '0;
        end else if (load_i) begin
            sck_q <= 1'b0;
            tx_sr <= tx_frame_i;
            idx_q <= '0;
        end else if (run_i && half_end_i) begin
            if (!sck_q) begin
                sck_q <= 1'b1;
                rx_sr <= {rx_sr[FRAME_W-2:0], miso_i};
            end else begin
                sck_q <= 1'b0;
                if (last_bit) begin
                    tx_sr <= '0;
                end else begin
                    idx_q <= idx_q + IX_W'(1);
                    tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
                end
            end
        end
    end

    AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !sck_q); // R4
    AST_MOSI_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && $past(run_i) && !$fell(sck_q) |-> $stable(mosi_o)); // R5
    AST_MOSI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !mosi_o); // R5

endmodule

// File: rtl/sbspi_master.sv
// Top of the short-burst SPI master: register block, half-period timer, bit engine.
// Assumes a single slave whose select line is owned by software.
module sbspi_master #(
    parameter int          ADDR_W  = 8,
    parameter int          DIV_W   = 12,
    parameter int unsigned DIV_RST = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);

    import sbspi_pkg::*;

    logic               busy, start, done, half_end;
    logic [FRAME_W-1:0] tx_frame, rx_frame;
    logic [CNT_W-1:0]   txe, rxe;
    logic [DIV_W-1:0]   div;

    sbspi_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .done_i(done), .rx_frame_i(rx_frame),
        .busy_o(busy), .start_o(start), .tx_frame_o(tx_frame),
        .txe_o(txe), .rxe_o(rxe), .div_o(div), .cs_n_o(spi_cs_n)
    );

    sbspi_clkgen #(.DIV_W(DIV_W)) i_clkgen (
        .clk(clk), .rst_n(rst_n), .run_i(busy), .div_i(div), .half_end_o(half_end)
    );

    sbspi_shift i_shift (
        .clk(clk), .rst_n(rst_n), .run_i(busy), .load_i(start),
        .tx_frame_i(tx_frame), .txe_i(txe), .rxe_i(rxe), .half_end_i(half_end),
        .miso_i(spi_miso), .sck_o(spi_sck), .mosi_o(spi_mosi),
        .rx_frame_o(rx_frame), .done_o(done)
    );

endmodule

// File: tb/test_sbspi_master.sv
// Bench: behavioural model of registers and serial timing, compared on every clock.
module test_sbspi_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        spi_sck, spi_mosi, spi_cs_n;
    logic        spi_miso = 1'b0;

    always #4 clk = ~clk;

    sbspi_master i_sbspi_master (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit finished = 0;

    // Model state
    logic [31:0] m_cmd, m_pay;
    logic [3:0]  m_txc, m_rxc;
    logic [11:0] m_div;
    logic [2:0]  m_ctl;
    logic        m_sel, m_busy;
    int          m_e, m_len, m_h, m_txe, m_rxe;
    logic [7:0]  m_txb [8];
    logic [7:0]  resp  [8];

    function automatic int eff(logic [3:0] c);
        return (c > 4'd8) ? 8 : int'(c);
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        case (a)
            8'h00: return {15'h0, m_busy, 7'h0, 1'b0, m_rxc, m_txc};
            8'h04: return m_cmd;
            8'h08: return m_pay;
            8'h28: return {m_ctl, 1'b0, m_div, 16'h0};
            8'h38: return {31'h0, m_sel};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic tx_bit(int k);
        if (k < 8 * m_txe) return m_txb[k/8][7 - k%8];
        return 1'b0;
    endfunction

    function automatic logic rx_bit(int k);
        int r;
        if (k < 8 * m_txe) return k[0] ^ k[2];
        r = k - 8 * m_txe;
        return resp[r/8][7 - r%8];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    // Reference model: register mirror and transfer clock counting.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cmd = 0; m_pay = 0; m_txc = 0; m_rxc = 0; m_div = 12'd3;
            m_ctl = 0; m_sel = 0; m_busy = 0; m_e = 0; m_len = 0;
        end else if (m_busy) begin
            if (m_e == m_len - 1) begin
                for (int j = 0; j < m_rxe; j++) begin
                    if (j < 4) m_pay[8*j +: 8] = resp[j];
                    else       m_cmd[8*(j-4) +: 8] = resp[j];
                end
                m_busy = 0;
            end else m_e++;
        end else if (bus_wr) begin
            case (bus_addr)
                8'h00: begin
                    m_txc = bus_wdata[3:0];
                    m_rxc = bus_wdata[7:4];
                    if (bus_wdata[8] && bus_wdata[7:0] != 0) begin
                        m_txe = eff(m_txc);
                        m_rxe = eff(m_rxc);
                        m_h   = int'(m_div) + 2;
                        m_len = 2 * m_h * 8 * (m_txe + m_rxe);
                        m_txb[0] = m_cmd[7:0];   m_txb[1] = m_cmd[31:24];
                        m_txb[2] = m_cmd[23:16]; m_txb[3] = m_cmd[15:8];
                        for (int i = 0; i < 4; i++) m_txb[4+i] = m_pay[8*i +: 8];
                        m_e = 0;
                        m_busy = 1;
                    end
                end
                8'h04: m_cmd = bus_wdata;
                8'h08: m_pay = bus_wdata;
                8'h28: begin m_div = bus_wdata[27:16]; m_ctl = bus_wdata[31:29]; end
                8'h38: m_sel = bus_wdata[0];
                default: ;
            endcase
        end
    end

    // Pin comparison and slave response, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 sck",  {31'h0, spi_sck},
                {31'h0, m_busy && ((m_e % (2*m_h)) >= m_h)});
            chk("R5 mosi", {31'h0, spi_mosi},
                {31'h0, m_busy ? tx_bit(m_e / (2*m_h)) : 1'b0});
            chk("R2 cs_n", {31'h0, spi_cs_n}, {31'h0, !m_sel});
            spi_miso <= m_busy ? rx_bit(m_e / (2*m_h)) : 1'b0;
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, string tag, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = bus_rdata;
        chk(tag, v, m_read(a));
    endtask

    task automatic poll_idle(string tag);
        logic [31:0] v;
        int guard = 0;
        do begin
            rd(8'h00, tag, v);
            guard++;
        end while (v[16] && guard < 20000);
    endtask

    task automatic xfer(logic [3:0] tx, logic [3:0] rx, string tag);
        logic [31:0] v;
        wr(8'h00, {24'h0, rx, tx});
        wr(8'h00, {23'h0, 1'b1, rx, tx});
        poll_idle("R3 busy");
        rd(8'h04, tag, v);
        rd(8'h08, tag, v);
    endtask

    task automatic set_resp(logic [7:0] seed);
        for (int i = 0; i < 8; i++) resp[i] = seed + 8'(i * 37);
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog (all) actual=%0d cycles expected<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        m_h = 5;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, "R1", v); rd(8'h04, "R1", v); rd(8'h08, "R1", v);
        rd(8'h28, "R1", v); rd(8'h38, "R1", v); rd(8'h10, "R1", v);

        // R2 register storage and chip select
        wr(8'h04, 32'h11223344); rd(8'h04, "R2", v);
        wr(8'h08, 32'hA5B6C7D8); rd(8'h08, "R2", v);
        wr(8'h28, 32'hFFFFFFFF); rd(8'h28, "R2", v);
        wr(8'h38, 32'hFFFFFFFF); rd(8'h38, "R2", v);
        wr(8'h28, 32'hE0000000); rd(8'h28, "R2", v);

        // R11 counts without go
        wr(8'h00, 32'h00000023); rd(8'h00, "R11", v);
        repeat (5) @(negedge clk);
        rd(8'h00, "R11", v);

        // R5/R6 mixed transfer, divider 0
        set_resp(8'h3C);
        xfer(4'd2, 4'd3, "R6 tx2 rx3");

        // R5/R6 full eight plus eight, divider 1
        wr(8'h28, 32'hE0010000);
        wr(8'h04, 32'h9A0F55C3); wr(8'h08, 32'h81422418);
        set_resp(8'h5A);
        xfer(4'd8, 4'd8, "R6 tx8 rx8");

        // R7 receive only
        wr(8'h28, 32'h00020000);
        set_resp(8'hE1);
        xfer(4'd0, 4'd4, "R7 rx only");

        // R6 transmit only leaves data words untouched
        wr(8'h04, 32'h0BADF00D); wr(8'h08, 32'hCAFE1234);
        xfer(4'd1, 4'd0, "R6 tx only");

        // R8 oversized counts act as eight
        wr(8'h28, 32'h00000000);
        set_resp(8'h17);
        xfer(4'hF, 4'h9, "R8 clamp");
        rd(8'h00, "R8", v);

        // R9 writes during a transfer are ignored
        set_resp(8'h99);
        wr(8'h00, 32'h00000044);
        wr(8'h00, 32'h00000144);
        wr(8'h00, 32'h00000188);
        wr(8'h04, 32'hDEADBEEF);
        wr(8'h38, 32'h00000000);
        wr(8'h28, 32'h0FFF0000);
        poll_idle("R9 busy");
        rd(8'h04, "R9", v); rd(8'h08, "R9", v);
        rd(8'h28, "R9", v); rd(8'h38, "R9", v);

        // R10 go with zero counts
        wr(8'h00, 32'h00000100);
        rd(8'h00, "R10", v);
        repeat (4) @(negedge clk);
        rd(8'h00, "R10", v);

        wr(8'h38, 32'h0);
        repeat (3) @(negedge clk);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule